// File: doc/BRIEF.md
# Select-Controlled Clock Divider Fanout

This block takes a single input clock and fans it out to eight differential output pairs and one complementary reference pair. Each output carries the input clock divided by 1, 2 or 4, and a 3-bit select code picks the ratio. The six standard pairs share one decode of the select code. Pairs 2 and 7 use a different decode, and for some codes that decode turns them off. The reference pair runs at divide-by-4 except for one code.

Every pad is modelled as a data bit plus an output-enable bit, so high impedance means the enable is low. A tristate control turns every output off. An asynchronous active-low power-down overrides everything else and puts the outputs in fixed parking levels.

All dividers come from one 2-bit down-counter, so the /1, /2 and /4 waveforms rise together at the start of every 4-cycle frame. A new select code is captured only at a frame start, so a ratio change never produces a runt pulse.

Top module: `clk_fanout_div`

## Requirements
- R1: Select is {A,B,U} = sel[2:0], with A in sel[2]. Pair n uses bit index n-1. On pairs 1, 3, 4, 5, 6 and 8, codes 000, 001, 010 and 111 give /2, code 011 gives /4, and codes 100, 101 and 110 give /1.
- R2: Pairs 2 and 7 (bit indices 1 and 6) decode as follows:
  - codes 000, 110 and 111 give /2;
  - codes 010 and 011 give /4;
  - code 100 gives /1;
  - codes 001 and 101 turn both legs off (both enables 0).
- R3: The reference pair divides by 4 for every code except 111, where it divides by 2.
- R4: While pwr_dn_n is 1 and tri_en is 1, every output enable (host_p_oe, host_n_oe, ref_p_oe, ref_n_oe) is 0, whatever the select code.
- R5: While pwr_dn_n is 0, the following hold, asynchronously and regardless of the other inputs:
  - ref_p and ref_n are driven 0 (enables 1);
  - every host_n_oe is 0;
  - every host_p is driven 1 (enable 1).
- R6: An enabled pair that is not powered down drives both enables at 1, with the negative leg the exact complement of the positive leg.
- R7: The select code becomes active only at a frame-start edge. Frames are 4 input cycles long. The first frame starts at the first rising edge after rst_n and pwr_dn_n are both high.
- R8: At each frame-start edge, every /2 and /4 output rises. A /2 output is high for cycles 1 and 3 of the frame, and a /4 output is high for cycles 1 and 2. A /1 output equals clk_in. Every divided output therefore has an exact 50% duty cycle.
- R9: While rst_n is 0, the /2 and /4 waveforms are low and the active select code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset of the dividers |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| tri_en | input | 1 | High turns every output off |
| sel | input | 3 | Ratio select {A,B,U} |
| host_p | output | 8 | Positive leg data, one bit per pair |
| host_n | output | 8 | Negative leg data, one bit per pair |
| host_p_oe | output | 8 | Positive leg output enable |
| host_n_oe | output | 8 | Negative leg output enable |
| ref_p | output | 1 | Reference true data |
| ref_n | output | 1 | Reference complement data |
| ref_p_oe | output | 1 | Reference true enable |
| ref_n_oe | output | 1 | Reference complement enable |

## Verification
The assertions check four rules on every edge: the power-down parking levels, the tristate override, the complement relation on enabled legs, and that the active select code changes only after the counter was at its frame-start value. They also check that /2 toggles every cycle and that /4 never rises without /2. Only the bench scenarios show that each code maps to the right ratio on the right pairs, that every half-cycle of each output has the expected level (and so the 50% duty cycle), and that a code change in the middle of a frame waits for the next frame.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    DIV_OFF = 2'd0,
    DIV_BY1 = 2'd1,
    DIV_BY2 = 2'd2,
    DIV_BY4 = 2'd3
  } div_e;

  // Decode shared by the six standard pairs.
  function automatic div_e dec_std(input logic [SEL_W-1:0] s);
    case (s)
      3'b011:                 return DIV_BY4;
      3'b100, 3'b101, 3'b110: return DIV_BY1;
      default:                return DIV_BY2;
    endcase
  endfunction

  // Decode used by the two alternate pairs.
  function automatic div_e dec_alt(input logic [SEL_W-1:0] s);
    case (s)
      3'b001, 3'b101: return DIV_OFF;
      3'b010, 3'b011: return DIV_BY4;
      3'b100:         return DIV_BY1;
      default:        return DIV_BY2;
    endcase
  endfunction

  // Decode for the reference pair.
  function automatic div_e dec_ref(input logic [SEL_W-1:0] s);
    return (s == 3'b111) ? DIV_BY2 : DIV_BY4;
  endfunction

endpackage

// File: rtl/clk_fanout_divcnt.sv
module clk_fanout_divcnt
  import clk_fanout_pkg::*;
#(
  parameter int MAX_DIV = 4,
  localparam int CNT_W = $clog2(MAX_DIV)
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             pwr_dn_n,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             div2,
  output logic             div4
);

  logic clr_n;
  logic frame_start;

  assign clr_n       = rst_n & pwr_dn_n;
  // The counter is at zero during the last cycle of a frame; the next edge opens a new one.
  assign frame_start = (cnt_q == '0);

  // Down-counter: 0 -> 3 -> 2 -> 1 -> 0, so both bits rise on the wrap.
  always_ff @(posedge clk_in or negedge clr_n) begin
    if (!clr_n) cnt_q <= '0;
    else        cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_in or negedge clr_n) begin
    if (!clr_n)           sel_act <= '0;
    else if (frame_start) sel_act <= sel_in;
  end

  assign div2 = cnt_q[0];
  assign div4 = cnt_q[CNT_W-1];

endmodule

// File: rtl/clk_fanout_pair.sv
module clk_fanout_pair
  import clk_fanout_pkg::*;
#(
  parameter bit PD_HOLD_LOW = 1'b0
) (
  input  logic clk_in,
  input  logic div2,
  input  logic div4,
  input  div_e mode,
  input  logic tri_en,
  input  logic pwr_dn_n,
  output logic out_p,
  output logic out_n,
  output logic out_p_oe,
  output logic out_n_oe
);

  logic wave;
  logic en;

  always_comb begin
    case (mode)
      DIV_BY1: wave = clk_in;
      DIV_BY2: wave = div2;
      DIV_BY4: wave = div4;
      default: wave = 1'b0;
    endcase
    en = (mode != DIV_OFF) && !tri_en;

    if (!pwr_dn_n) begin
      if (PD_HOLD_LOW) begin
        out_p    = 1'b0;
        out_n    = 1'b0;
        out_p_oe = 1'b1;
        out_n_oe = 1'b1;
      end else begin
        out_p    = 1'b1;
        out_n    = 1'b0;
        out_p_oe = 1'b1;
        out_n_oe = 1'b0;
      end
    end else begin
      out_p    = en & wave;
      out_n    = en & ~wave;
      out_p_oe = en;
      out_n_oe = en;
    end
  end

endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div
  import clk_fanout_pkg::*;
#(
  parameter int                   NUM_PAIRS = 8,
  parameter logic [NUM_PAIRS-1:0] ALT_MASK  = 8'b0100_0010,
  parameter int                   MAX_DIV   = 4,
  localparam int                  CNT_W     = $clog2(MAX_DIV)
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic                 pwr_dn_n,
  input  logic                 tri_en,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_PAIRS-1:0] host_p,
  output logic [NUM_PAIRS-1:0] host_n,
  output logic [NUM_PAIRS-1:0] host_p_oe,
  output logic [NUM_PAIRS-1:0] host_n_oe,
  output logic                 ref_p,
  output logic                 ref_n,
  output logic                 ref_p_oe,
  output logic                 ref_n_oe
);

  logic [SEL_W-1:0] sel_act;
  logic [CNT_W-1:0] cnt_q;
  logic             div2;
  logic             div4;

  clk_fanout_divcnt #(.MAX_DIV(MAX_DIV)) u_cnt (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .sel_in   (sel),
    .sel_act  (sel_act),
    .cnt_q    (cnt_q),
    .div2     (div2),
    .div4     (div4)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    div_e mode;
    if (ALT_MASK[i]) begin : g_alt
      assign mode = dec_alt(sel_act);
    end else begin : g_std
      assign mode = dec_std(sel_act);
    end

    clk_fanout_pair #(.PD_HOLD_LOW(1'b0)) u_drv (
      .clk_in   (clk_in),
      .div2     (div2),
      .div4     (div4),
      .mode     (mode),
      .tri_en   (tri_en),
      .pwr_dn_n (pwr_dn_n),
      .out_p    (host_p[i]),
      .out_n    (host_n[i]),
      .out_p_oe (host_p_oe[i]),
      .out_n_oe (host_n_oe[i])
    );
  end

  div_e ref_mode;
  assign ref_mode = dec_ref(sel_act);

  clk_fanout_pair #(.PD_HOLD_LOW(1'b1)) u_ref (
    .clk_in   (clk_in),
    .div2     (div2),
    .div4     (div4),
    .mode     (ref_mode),
    .tri_en   (tri_en),
    .pwr_dn_n (pwr_dn_n),
    .out_p    (ref_p),
    .out_n    (ref_n),
    .out_p_oe (ref_p_oe),
    .out_n_oe (ref_n_oe)
  );

endmodule

// File: rtl/clk_fanout_chk.sv
module clk_fanout_chk #(
  parameter int NUM_PAIRS = 8,
  parameter int CNT_W     = 2,
  parameter int SEL_W     = 3
) (
  input logic                 clk_in,
  input logic                 rst_n,
  input logic                 pwr_dn_n,
  input logic                 tri_en,
  input logic [NUM_PAIRS-1:0] host_p,
  input logic [NUM_PAIRS-1:0] host_n,
  input logic [NUM_PAIRS-1:0] host_p_oe,
  input logic [NUM_PAIRS-1:0] host_n_oe,
  input logic                 ref_p,
  input logic                 ref_n,
  input logic                 ref_p_oe,
  input logic                 ref_n_oe,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [SEL_W-1:0]     sel_act,
  input logic                 div2,
  input logic                 div4
);

  assert_pd_park_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    !pwr_dn_n |-> (host_p == '1 && host_p_oe == '1 && host_n_oe == '0 &&
                   !ref_p && !ref_n && ref_p_oe && ref_n_oe));

  assert_tri_off_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (pwr_dn_n && tri_en) |-> (host_p_oe == '0 && host_n_oe == '0 && !ref_p_oe && !ref_n_oe));

  assert_complement_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    pwr_dn_n |-> (((host_p ^ host_n) & host_p_oe) == host_p_oe &&
                  host_p_oe == host_n_oe &&
                  (!ref_p_oe || (ref_p != ref_n))));

  assert_sel_at_frame_R7: assert property (@(posedge clk_in) disable iff (!rst_n || !pwr_dn_n)
    (sel_act != $past(sel_act)) |-> ($past(cnt_q) == '0));

  assert_div2_toggle_R8: assert property (@(posedge clk_in) disable iff (!rst_n || !pwr_dn_n)
    $past(rst_n && pwr_dn_n) |-> (div2 != $past(div2)));

  assert_edge_align_R8: assert property (@(posedge clk_in) disable iff (!rst_n || !pwr_dn_n)
    $rose(div4) |-> div2);

endmodule

bind clk_fanout_div clk_fanout_chk #(
  .NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W), .SEL_W(clk_fanout_pkg::SEL_W)
) u_chk (.*);

// File: tb/tb_clk_fanout_div.sv
`timescale 1ns/100ps
module tb_clk_fanout_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 1'b1;
  logic       tri_en = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [7:0] host_p, host_n, host_p_oe, host_n_oe;
  logic       ref_p, ref_n, ref_p_oe, ref_n_oe;

  int   n_chk = 0;
  int   n_err = 0;
  int   k = 0;
  logic [2:0] eff = 3'b000;
  string ph_tag = "R9";

  always #2.5 clk = ~clk;

  clk_fanout_div dut (
    .clk_in(clk), .rst_n(rst_n), .pwr_dn_n(pwr), .tri_en(tri_en), .sel(sel),
    .host_p(host_p), .host_n(host_n), .host_p_oe(host_p_oe), .host_n_oe(host_n_oe),
    .ref_p(ref_p), .ref_n(ref_n), .ref_p_oe(ref_p_oe), .ref_n_oe(ref_n_oe)
  );

  // Ratio codes: 0 off, 1, 2, 4.
  function automatic int exp_std(logic [2:0] s);
    if (s == 3'b011) return 4;
    if (s == 3'b100 || s == 3'b101 || s == 3'b110) return 1;
    return 2;
  endfunction

  function automatic int exp_alt(logic [2:0] s);
    if (s == 3'b001 || s == 3'b101) return 0;
    if (s == 3'b010 || s == 3'b011) return 4;
    if (s == 3'b100) return 1;
    return 2;
  endfunction

  function automatic int exp_ref(logic [2:0] s);
    return (s == 3'b111) ? 2 : 4;
  endfunction

  function automatic logic wave(int d, int kk, bit hi);
    if (d == 1) return hi;
    if (d == 2) return (kk % 2) == 1;
    if (d == 4) return ((kk % 4) == 1) || ((kk % 4) == 2);
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_leg(string base, int d, bit is_ref, bit hi,
                         logic p, logic n, logic poe, logic noe);
    logic w;
    if (!pwr) begin
      chk({base, " R5 p"}, p, is_ref ? 1'b0 : 1'b1);
      chk({base, " R5 poe"}, poe, 1'b1);
      chk({base, " R5 noe"}, noe, is_ref ? 1'b1 : 1'b0);
      if (is_ref) chk({base, " R5 n"}, n, 1'b0);
    end else if (tri_en) begin
      chk({base, " R4 poe"}, poe, 1'b0);
      chk({base, " R4 noe"}, noe, 1'b0);
    end else if (d == 0) begin
      chk({base, " R6 off poe"}, poe, 1'b0);
      chk({base, " R6 off noe"}, noe, 1'b0);
    end else begin
      w = wave(d, k, hi);
      chk({base, " R6 poe"}, poe, 1'b1);
      chk({base, " R6 noe"}, noe, 1'b1);
      chk({base, " ", ph_tag, " p"}, p, w);
      chk({base, " R6 n"}, n, ~w);
    end
  endtask

  task automatic check_all(bit hi);
    for (int i = 0; i < 8; i++) begin
      bit alt = (i == 1) || (i == 6);
      chk_leg($sformatf("%s pair%0d", alt ? "R2" : "R1", i + 1),
              alt ? exp_alt(eff) : exp_std(eff), 1'b0, hi,
              host_p[i], host_n[i], host_p_oe[i], host_n_oe[i]);
    end
    chk_leg("R3 ref", exp_ref(eff), 1'b1, hi, ref_p, ref_n, ref_p_oe, ref_n_oe);
  endtask

  // One input cycle: update the model at the edge, sample both halves, return at edge+4ns.
  task automatic step();
    @(posedge clk);
    if (!rst_n || !pwr) begin
      k = 0;
      eff = 3'b000;
    end else begin
      k++;
      if ((k % 4) == 1) eff = sel;
    end
    #1;
    check_all(1'b1);
    #2.5;
    check_all(1'b0);
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1F2E3D4C);
    // R9: reset state
    ph_tag = "R9";
    sel = 3'b110;
    for (int i = 0; i < 6; i++) step();
    rst_n = 1'b1;
    // R8: every code held for several frames
    ph_tag = "R8";
    for (int c = 0; c < 8; c++) begin
      sel = c[2:0];
      for (int i = 0; i < 12; i++) step();
    end
    // R4: tristate over a /1 code
    sel = 3'b100;
    for (int i = 0; i < 4; i++) step();
    tri_en = 1'b1;
    for (int i = 0; i < 5; i++) step();
    tri_en = 1'b0;
    // R5: power-down with tristate also high, then recovery
    pwr = 1'b0;
    tri_en = 1'b1;
    for (int i = 0; i < 5; i++) step();
    tri_en = 1'b0;
    for (int i = 0; i < 3; i++) step();
    pwr = 1'b1;
    for (int i = 0; i < 8; i++) step();
    // R7: a mid-frame change must wait for the next frame
    ph_tag = "R7";
    sel = 3'b011;
    for (int i = 0; i < 6; i++) step();
    sel = 3'b100;
    step();
    sel = 3'b010;
    for (int i = 0; i < 9; i++) step();
    // random mix
    for (int i = 0; i < 500; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 30) sel = 3'($urandom);
      else if (r < 35) tri_en = ~tri_en;
      else if (r < 38) pwr = ~pwr;
      step();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule